// File: doc/BRIEF.md
# Serial EEPROM Write-Guard and Status Register

This block sits beside the command decoder of a small serial EEPROM and answers one question for every attempted modification: may this byte be written now? It keeps the volatile write-enable latch and the two block-lock bits, and it forms the status byte that the decoder shifts out when software reads the status. The decoder hands it single-cycle strobes: set enable, clear enable, status write (with its data byte), and array write finished. It also hands it the end of every internal write cycle, the level of the hardware protect pin, the busy flag of the write timer and the array address being targeted.

The write permission is combinational on the address, the enable latch, the protect pin and the lock bits, so the decoder can qualify each incoming data byte in the cycle it arrives. A status write only records the new lock level once it is accepted. The stored lock level changes when the internal write cycle that follows completes, and the enable latch clears at that moment. The lock register resets to zero and otherwise keeps its value for as long as the block is powered, standing in for non-volatile cells. The array size is a parameter, 256 or 512 bytes, and the locked ranges scale with it.

All interfaces are plain level or single-cycle strobe signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. A strobe is seen in the cycle it is high.

Top module: `eewp_guard`

## Requirements
- R1: When not busy, the status byte reads bit 0 = 0 (ready), bit 1 = write-enable latch, bit 2 = lock bit 0, bit 3 = lock bit 1, and bits 7:4 = 0.
- R2: While `busy_i` is high the status byte reads 8'hFF.
- R3: After reset the enable latch and both lock bits are 0: status 8'h00 and no address is writable.
- R4: A set-enable strobe with the pin high and not busy sets the latch by the next cycle. A clear-enable strobe clears it. When both strobes arrive together, clear wins.
- R5: While `wp_n_i` is low the latch is cleared and cannot be set, and `permit_o` is 0 for every address.
- R6: `permit_o` is 1 only when the latch is 1, the pin is high and the address lies outside the locked range. Lock 2'b00 locks nothing. Lock 2'b01 locks the top quarter (180h-1FFh for 512 bytes, C0h-FFh for 256). Lock 2'b10 locks the top half (100h-1FFh or 80h-FFh). Lock 2'b11 locks everything.
- R7: A status write is refused unless the latch is 1 and the pin is high. A refused write leaves the lock bits unchanged after the next write-cycle end.
- R8: An accepted status write takes its data bits 3:2 as the new lock level. The stored lock level and the status byte change only at the next write-cycle end, and the latch clears at that moment. Data bits 7:4 and 1:0 are discarded.
- R9: An array-write-finished strobe clears the latch.
- R10: Set-enable, clear-enable and status-write strobes that arrive while `busy_i` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Set-enable strobe |
| wrdi_i | input | 1 | Clear-enable strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_byte_i | input | 8 | Data byte of the status write |
| arr_wr_i | input | 1 | Array write finished strobe |
| cyc_done_i | input | 1 | Internal write cycle finished strobe |
| wp_n_i | input | 1 | Hardware protect pin, low = protect |
| busy_i | input | 1 | Internal write cycle in progress |
| addr_i | input | ADDR_W | Target array address |
| status_o | output | 8 | Status byte for reads |
| permit_o | output | 1 | Write allowed at `addr_i` |

## Verification
The bench builds two copies side by side, one with the default 512-byte array and one with 256 bytes, and drives them with the same strobes. Both copies therefore hold identical latch and lock state. A single table of lock level and address pairs then probes the first and last address of every locked range in both sizes. This brings the off-by-one boundaries at C0h/80h and 180h/100h into reach. The 512-byte copy also shows that address bit 8 takes part in the decision, which the smaller copy lacks.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

  localparam int STAT_W  = 8;
  localparam int ST_BUSY = 0;
  localparam int ST_WEN  = 1;
  localparam int ST_LK0  = 2;
  localparam int ST_LK1  = 3;

  // Position of the lock field inside a status-write data byte.
  localparam int LK_LSB  = 2;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_lvl_e;

endpackage

// File: rtl/eewp_enable_latch.sv
module eewp_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n_i,
  input  logic busy_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic done_clr_i,
  output logic wen_o
);

  logic wen_q;

  // Pin and completed writes clear unconditionally. Commands are honoured
  // only while idle, and clear beats set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
    end else if (!wp_n_i || done_clr_i) begin
      wen_q <= 1'b0;
    end else if (!busy_i && clr_i) begin
      wen_q <= 1'b0;
    end else if (!busy_i && set_i) begin
      wen_q <= 1'b1;
    end
  end

  assign wen_o = wen_q;

  a_r5_pin_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n_i |=> !wen_o);

  a_r4_set_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_n_i && !busy_i && set_i && !clr_i && !done_clr_i) |=> wen_o);

  a_r10_busy_freezes_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && wp_n_i && !done_clr_i) |=> $stable(wen_o));

endmodule

// File: rtl/eewp_lock_store.sv
module eewp_lock_store
  import eewp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrsr_i,
  input  logic [STAT_W-1:0] wrsr_byte_i,
  input  logic              wen_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              cyc_done_i,
  output lock_lvl_e         lock_o,
  output logic              commit_o
);

  logic      pend_q;
  lock_lvl_e pend_lvl_q;
  lock_lvl_e lock_q;
  logic      accept;

  assign accept   = wrsr_i && !busy_i && wen_i && wp_n_i && !pend_q;
  assign commit_o = cyc_done_i && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_lvl_q <= LOCK_NONE;
      lock_q     <= LOCK_NONE;
    end else begin
      if (commit_o) begin
        lock_q <= pend_lvl_q;
        pend_q <= 1'b0;
      end else if (accept) begin
        pend_q     <= 1'b1;
        pend_lvl_q <= lock_lvl_e'(wrsr_byte_i[LK_LSB +: 2]);
      end
    end
  end

  assign lock_o = lock_q;

  a_r8_lock_moves_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_done_i && pend_q) |=> $stable(lock_o));

  a_r7_refused_leaves_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_i && !(wen_i && wp_n_i) && !pend_q) |=> !pend_q);

endmodule

// File: rtl/eewp_range_decode.sv
module eewp_range_decode
  import eewp_pkg::*;
#(
  parameter  int ARRAY_BYTES = 512,
  localparam int ADDR_W      = $clog2(ARRAY_BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  lock_lvl_e         lock_i,
  output logic              locked_o
);

  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(ARRAY_BYTES - ARRAY_BYTES / 4);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(ARRAY_BYTES / 2);

  always_comb begin
    unique case (lock_i)
      LOCK_NONE: locked_o = 1'b0;
      LOCK_QTR:  locked_o = (addr_i >= QTR_BASE);
      LOCK_HALF: locked_o = (addr_i >= HALF_BASE);
      default:   locked_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/eewp_guard.sv
module eewp_guard
  import eewp_pkg::*;
#(
  parameter  int ARRAY_BYTES = 512,
  localparam int ADDR_W      = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [STAT_W-1:0] wrsr_byte_i,
  input  logic              arr_wr_i,
  input  logic              cyc_done_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              permit_o
);

  logic      wen;
  logic      commit;
  logic      locked;
  lock_lvl_e lock;

  eewp_enable_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n_i     (wp_n_i),
    .busy_i     (busy_i),
    .set_i      (wren_i),
    .clr_i      (wrdi_i),
    .done_clr_i (commit || arr_wr_i),
    .wen_o      (wen)
  );

  eewp_lock_store u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrsr_i      (wrsr_i),
    .wrsr_byte_i (wrsr_byte_i),
    .wen_i       (wen),
    .wp_n_i      (wp_n_i),
    .busy_i      (busy_i),
    .cyc_done_i  (cyc_done_i),
    .lock_o      (lock),
    .commit_o    (commit)
  );

  eewp_range_decode #(.ARRAY_BYTES(ARRAY_BYTES)) u_range (
    .addr_i   (addr_i),
    .lock_i   (lock),
    .locked_o (locked)
  );

  always_comb begin
    if (busy_i) begin
      status_o = '1;
    end else begin
      status_o          = '0;
      status_o[ST_WEN]  = wen;
      status_o[ST_LK0]  = lock[0];
      status_o[ST_LK1]  = lock[1];
    end
  end

  assign permit_o = wen && wp_n_i && !locked;

  a_r6_full_lock_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (lock == LOCK_ALL) |-> !permit_o);

  a_r5_pin_low_denies: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n_i |-> !permit_o);

  a_r1_upper_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (status_o[7:4] == 4'h0));

endmodule

// File: tb/eewp_guard_test.sv
module eewp_guard_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
  logic [7:0] wrsr_byte = 8'h00;
  logic       arr_wr = 1'b0, cyc_done = 1'b0;
  logic       wp_n = 1'b1, busy = 1'b0;
  logic [8:0] addr = 9'h000;
  logic [7:0] status_a, status_b;
  logic       permit_a, permit_b;
  int         n_cmp = 0;
  int         n_bad = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  eewp_guard #(.ARRAY_BYTES(512)) uut (
    .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wrsr_byte_i(wrsr_byte), .arr_wr_i(arr_wr), .cyc_done_i(cyc_done),
    .wp_n_i(wp_n), .busy_i(busy), .addr_i(addr),
    .status_o(status_a), .permit_o(permit_a)
  );

  eewp_guard #(.ARRAY_BYTES(256)) uut_small (
    .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wrsr_byte_i(wrsr_byte), .arr_wr_i(arr_wr), .cyc_done_i(cyc_done),
    .wp_n_i(wp_n), .busy_i(busy), .addr_i(addr[7:0]),
    .status_o(status_b), .permit_o(permit_b)
  );

  // {lock[1:0], addr[8:0], permit_512, permit_256}; the 256 copy sees addr[7:0]
  localparam logic [12:0] VEC [12] = '{
    {2'b00, 9'h000, 1'b1, 1'b1},
    {2'b00, 9'h1FF, 1'b1, 1'b1},
    {2'b01, 9'h17F, 1'b1, 1'b1},
    {2'b01, 9'h180, 1'b0, 1'b1},
    {2'b01, 9'h0BF, 1'b1, 1'b1},
    {2'b01, 9'h0C0, 1'b1, 1'b0},
    {2'b10, 9'h0FF, 1'b1, 1'b0},
    {2'b10, 9'h100, 1'b0, 1'b1},
    {2'b10, 9'h07F, 1'b1, 1'b1},
    {2'b10, 9'h080, 1'b1, 1'b0},
    {2'b11, 9'h000, 1'b0, 1'b0},
    {2'b11, 9'h1FF, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic pulse_wren;
    wren = 1'b1; step(); wren = 1'b0;
  endtask

  task automatic pulse_wrdi;
    wrdi = 1'b1; step(); wrdi = 1'b0;
  endtask

  task automatic pulse_wrsr(input logic [7:0] b);
    wrsr = 1'b1; wrsr_byte = b; step(); wrsr = 1'b0;
  endtask

  task automatic pulse_done;
    cyc_done = 1'b1; step(); cyc_done = 1'b0;
  endtask

  task automatic set_lock(input logic [1:0] lvl);
    pulse_wren();
    pulse_wrsr({4'hA, lvl, 2'b01});
    pulse_done();
    pulse_wren();
  endtask

  initial begin
    repeat (3) step();
    #1 chk("R3 reset status", status_a, 8'h00);
    chk("R3 reset permit", {7'b0, permit_a}, 8'h00);
    rst_n = 1'b1;
    step();

    pulse_wren();
    chk("R4 set latch", status_a, 8'h02);
    chk("R6 open array permit", {7'b0, permit_a}, 8'h01);
    pulse_wrdi();
    chk("R4 clear latch", status_a, 8'h00);
    wren = 1'b1; wrdi = 1'b1; step(); wren = 1'b0; wrdi = 1'b0;
    chk("R4 clear wins", status_a, 8'h00);

    pulse_wren();
    busy = 1'b1; #1;
    chk("R2 busy all ones", status_a, 8'hFF);
    chk("R2 busy all ones 256", status_b, 8'hFF);
    step(); pulse_wrdi(); busy = 1'b0; #1;
    chk("R10 clear ignored while busy", status_a, 8'h02);

    wp_n = 1'b0; step();
    chk("R5 pin clears latch", status_a, 8'h00);
    pulse_wren();
    chk("R5 set blocked by pin", status_a, 8'h00);
    chk("R5 permit low with pin", {7'b0, permit_a}, 8'h00);
    wp_n = 1'b1; step();

    pulse_wrsr(8'hFF); pulse_done();
    chk("R7 status write refused without latch", status_a, 8'h00);

    pulse_wren();
    busy = 1'b1; pulse_wrsr(8'hFF); busy = 1'b0;
    pulse_done();
    chk("R10 status write ignored while busy", status_a, 8'h02);

    pulse_wrsr(8'hF8);
    chk("R8 lock unchanged before cycle end", status_a, 8'h02);
    pulse_done();
    chk("R8 lock committed, latch cleared", status_a, 8'h08);
    chk("R1 layout 256 copy", status_b, 8'h08);

    pulse_wren();
    pulse_wrdi(); pulse_wren();
    arr_wr = 1'b1; step(); arr_wr = 1'b0;
    chk("R9 array write clears latch", status_a, 8'h08);

    for (int i = 0; i < 12; i++) begin
      set_lock(VEC[i][12:11]);
      addr = VEC[i][10:2];
      #1;
      chk("R6 permit 512", {7'b0, permit_a}, {7'b0, VEC[i][1]});
      chk("R6 permit 256", {7'b0, permit_b}, {7'b0, VEC[i][0]});
      chk("R1 status after lock", status_a, {4'h0, VEC[i][12:11], 2'b10});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule